// File: doc/BRIEF.md
# Accumulating Eight-Function ALU

This block is a small accumulator datapath. A combinational unit combines a 4-bit external operand with a 4-bit feedback operand taken from the low half of an 8-bit result register. A 3-bit function code selects one of eight operations. On every rising clock edge the register takes the unit's 8-bit output. The one exception is the hold code, which leaves the register as it is.

The operations are:

- two additions that must agree: an explicit ripple-carry chain and the language's own addition operator;
- two half-and-half logic mixes, where each nibble of the result comes from a different bitwise function;
- two flag-style patterns, one from an OR over all operand bits and one from a pair of population-count tests;
- a swap-and-invert packing;
- hold.

Because the feedback operand comes from the register, a chain of codes applied over successive cycles builds up a value. This is how the block is used: load through an addition from a cleared register, then transform that value step by step.

Top module: `acc_alu`

## Requirements
- R1: When `rst_n` is 0 at a rising clock edge, `acc_q` becomes 8'h00 after that edge. Driving `rst_n` low between edges leaves `acc_q` unchanged until the next rising edge.
- R2: Operand B is `acc_q[3:0]`. For every code other than 7, with `rst_n` at 1, `acc_q` takes the value `alu_out` had before the rising edge.
- R3: Code 0 gives `din_a + B`. The sum is formed by a ripple-carry chain, kept as 5 bits including the carry out, and zero-extended to 8 bits.
- R4: Code 1 gives `din_a + B` through the addition operator, as 5 bits zero-extended. It equals the code 0 result for every operand pair.
- R5: Code 2 gives NOR(A,B) in bits 7:4 and NAND(A,B) in bits 3:0.
- R6: Code 3 gives 8'hC0 if any of the eight bits of A and B is 1, and 8'h00 otherwise.
- R7: Code 4 gives 8'h3F when A has exactly two ones and B has exactly three ones, and 8'h00 otherwise.
- R8: Code 5 gives B in bits 7:4 and the inverse of A in bits 3:0.
- R9: Code 6 gives A XOR B in bits 7:4 and A XNOR B in bits 3:0.
- R10: Code 7 shows the present `acc_q` on `alu_out`, and `acc_q` does not change at the edge.
- R11: A low `rst_n` takes precedence over code 7: the register clears even while hold is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous clear, active low |
| din_a | input | 4 | External operand A |
| fsel | input | 3 | Function code 0..7 |
| alu_out | output | 8 | Combinational result |
| acc_q | output | 8 | Result register; bits 3:0 feed operand B |

## Verification
Two functions can meet in one cycle: the synchronous clear and the hold code. The bench selects code 7 with `rst_n` low after the register holds a nonzero value. Clear is judged the winner when `acc_q` reads zero after the edge. Separately, `rst_n` is lowered right after a falling edge, and `acc_q` is compared before the next rising edge to confirm that nothing changed early.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int NIB = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NIB-1:0]   din_a,
  input  logic [2:0]       fsel,
  output logic [2*NIB-1:0] alu_out,
  output logic [2*NIB-1:0] acc_q
);
  localparam int W = 2 * NIB;

  logic [NIB-1:0] opb;
  assign opb = acc_q[NIB-1:0];

  // ripple-carry chain for code 0 (R3)
  logic [NIB:0]   cy;
  logic [NIB-1:0] rsum;
  assign cy[0] = 1'b0;
  for (genvar i = 0; i < NIB; i++) begin : g_rca
    assign rsum[i]  = din_a[i] ^ opb[i] ^ cy[i];
    assign cy[i+1]  = (din_a[i] & opb[i]) | (cy[i] & (din_a[i] ^ opb[i]));
  end

  logic [NIB:0] rc_sum, op_sum;
  assign rc_sum = {cy[NIB], rsum};
  assign op_sum = {1'b0, din_a} + {1'b0, opb};

  logic any_one, pop_hit;
  assign any_one = |{din_a, opb};
  assign pop_hit = ($countones(din_a) == 2) && ($countones(opb) == 3);

  always_comb begin
    alu_out = acc_q;
    case (fsel)
      3'd0: alu_out = W'(rc_sum);
      3'd1: alu_out = W'(op_sum);
      3'd2: alu_out = {~(din_a | opb), ~(din_a & opb)};
      3'd3: alu_out = any_one ? {2'b11, {(W-2){1'b0}}} : '0;
      3'd4: alu_out = pop_hit ? {2'b00, {(W-2){1'b1}}} : '0;
      3'd5: alu_out = {opb, ~din_a};
      3'd6: alu_out = {din_a ^ opb, ~(din_a ^ opb)};
      default: alu_out = acc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            acc_q <= '0;
    else if (fsel != 3'd7) acc_q <= alu_out;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> acc_q == '0);

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fsel != 3'd7) |=> acc_q == $past(alu_out));

  assert_adders_agree_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rc_sum == op_sum);

  assert_or_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fsel == 3'd3) |-> (alu_out == '0 || alu_out == {2'b11, {(W-2){1'b0}}}));

  assert_pop_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fsel == 3'd4 && alu_out != '0) |-> ($countones(din_a) == 2 && $countones(opb) == 3));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fsel == 3'd7) |=> $stable(acc_q));
endmodule

// File: tb/acc_alu_test.sv
module acc_alu_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] din_a = 4'd0;
  logic [2:0] fsel = 3'd0;
  logic [7:0] alu_out, acc_q;

  int total = 0, bad = 0;
  logic [7:0] macc = 8'h00;

  typedef struct {
    logic [7:0] alu;
    logic [7:0] prev;
    logic [7:0] nxt;
    int ra;
    int rn;
  } item_t;
  item_t sb[$];

  acc_alu uut (.clk(clk), .rst_n(rst_n), .din_a(din_a), .fsel(fsel),
               .alu_out(alu_out), .acc_q(acc_q));

  always #10 clk = ~clk;

  function automatic int ones(input logic [3:0] v);
    int n = 0;
    for (int i = 0; i < 4; i++) n += v[i];
    return n;
  endfunction

  function automatic logic [7:0] model(input logic [3:0] a, input logic [2:0] f,
                                       input logic [7:0] acc);
    logic [3:0] b = acc[3:0];
    logic [4:0] s = a + b;
    case (f)
      3'd0, 3'd1: return {3'b000, s};
      3'd2: return {~(a | b), ~(a & b)};
      3'd3: return ((a != 0) || (b != 0)) ? 8'hC0 : 8'h00;
      3'd4: return (ones(a) == 2 && ones(b) == 3) ? 8'h3F : 8'h00;
      3'd5: return {b, ~a};
      3'd6: return {a ^ b, ~(a ^ b)};
      default: return acc;
    endcase
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input int r,
                       input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and queues what must come out
  task automatic go(input logic r, input logic [3:0] a, input logic [2:0] f);
    item_t it;
    @(negedge clk);
    rst_n = r; din_a = a; fsel = f;
    it.alu  = model(a, f, macc);
    it.prev = macc;
    it.nxt  = !r ? 8'h00 : (f == 3'd7 ? macc : it.alu);
    it.ra   = int'(f) + 3;
    it.rn   = !r ? (f == 3'd7 ? 11 : 1) : (f == 3'd7 ? 10 : 2);
    sb.push_back(it);
    macc = it.nxt;
  endtask

  // monitor: pops each item and compares before and after the edge
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #5;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        check(alu_out, it.alu, it.ra, "alu_out");
        check(acc_q, it.prev, (it.rn == 1 || it.rn == 11) ? 1 : 2, "acc_q before edge");
        @(posedge clk);
        #2;
        check(acc_q, it.nxt, it.rn, "acc_q after edge");
      end
    end
  end

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    go(1'b0, 4'h0, 3'd0);            // R1 clear from power-up
    go(1'b1, 4'h5, 3'd1);            // R4 operator add, R2 capture
    go(1'b1, 4'hF, 3'd0);            // R3 ripple add with carry
    go(1'b1, 4'hF, 3'd1);            // R4 carry out
    go(1'b1, 4'hA, 3'd2);            // R5 nand/nor halves
    go(1'b1, 4'h3, 3'd4);            // R7 condition true
    go(1'b1, 4'h3, 3'd4);            // R7 condition false (B has four ones)
    go(1'b1, 4'h0, 3'd3);            // R6 all zero -> 00
    go(1'b1, 4'h8, 3'd3);            // R6 one bit set -> C0
    go(1'b1, 4'h6, 3'd5);            // R8 swap and invert
    go(1'b1, 4'h5, 3'd6);            // R9 xor/xnor halves
    go(1'b1, 4'h9, 3'd7);            // R10 hold
    go(1'b1, 4'h2, 3'd7);            // R10 hold again
    go(1'b0, 4'h1, 3'd7);            // R11 clear beats hold
    go(1'b1, 4'hF, 3'd0);            // R3 load F
    go(1'b1, 4'h0, 3'd1);            // R4
    go(1'b0, 4'h4, 3'd1);            // R1 reset lowered between edges
    for (int i = 0; i < 64; i++)
      go(1'b1, 4'((i * 7 + 3) % 16), 3'(i % 8));  // R2..R10 mixed chain
    go(1'b1, 4'h0, 3'd7);
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule